// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block sits beside a small 8-bit processor core and decides when the core must break off into an interrupt routine. Four peripheral events arrive as one-cycle strobes: a timer overflow, an A/D end-of-conversion, and a byte-complete event from each of two SPI ports. Each strobe sets a pending flag. A pending flag is only taken when its own enable, the global enable and the stack-not-full condition all agree. The two SPI sources also need a serial-bus enable. Flags whose enable is off stay pending until they are serviced or cleared by software.

When a request is taken, the controller raises a call request to the core for exactly one cycle, together with a fixed 8-bit vector. The vectors are 08h for the timer, 0Ch for A/D, 10h for SPI A and 14h for SPI B. It then waits for the core's acknowledge. On that acknowledge it clears the serviced flag and the global enable, so that further interrupts stay blocked until software sets the global enable again. Only the program counter is saved by the core on entry, so the routine itself must save any other context it changes.

The sequencer has three states. IDLE moves to CALL on *take*, when at least one source is eligible. CALL always moves to WAIT on *issue*, which is the single cycle of the call request. WAIT moves back to IDLE on *ack*. A small register window gives software read and write access to the enable and flag bits. A wake-up output tells the power manager that an enabled request is pending.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all flags, source enables, the global enable and the serial-bus enable are 0, and `call_req_o`, `wake_o` and `reg_rdata_o` are all 0.
- R2: A strobe on an event input sets that source's flag at the next clock edge. The event wins over a software write or an acknowledge clear of the same flag in the same cycle.
- R3: A source is eligible when the global enable, its source enable and its flag are all 1 and `stack_full_i` is 0. The SPI sources also need the serial-bus enable. If a source is eligible in IDLE during cycle n, `call_req_o` is 1 during cycle n+1, for exactly one cycle.
- R4: `call_vec_o` is 08h for the timer, 0Ch for A/D, 10h for SPI A and 14h for SPI B while `call_req_o` is 1, and 00h otherwise.
- R5: When several sources are eligible together, the one with the lowest vector is taken. The order is timer, A/D, SPI A, SPI B.
- R6: `call_ack_i` in WAIT clears the serviced flag and the global enable at the next edge, and this clear wins over a software write in the same cycle. An acknowledge in IDLE or CALL is ignored.
- R7: A flag whose enable (source or global) is 0 stays set, and no new call request is issued while WAIT is pending.
- R8: Register map. Address 0 holds the enables: bit0 global, bit1 serial-bus, bits 2..5 source enables for timer, A/D, SPI A and SPI B, and bits 7:6 read 0. Address 1 holds the flags: bits 0..3 in the same source order, and bits 7:4 read 0. A write takes effect at the edge. `reg_rd_i` loads `reg_rdata_o` with the value from before the edge, and `reg_rdata_o` holds otherwise.
- R9: Writing 1 to the global enable after service re-arms the controller, so a flag still pending is then taken.
- R10: `wake_o` is 1 whenever some flag is set together with its source enable. It does not depend on the global enable, the serial-bus enable or the stack state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_ovf_i | input | 1 | Timer overflow strobe |
| adc_done_i | input | 1 | A/D conversion complete strobe |
| spi_a_done_i | input | 1 | SPI A byte complete strobe |
| spi_b_done_i | input | 1 | SPI B byte complete strobe |
| stack_full_i | input | 1 | Core call stack has no free entry |
| call_ack_i | input | 1 | Core has entered the interrupt routine |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 1 | Register select: 0 enables, 1 flags |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Registered read data |
| call_req_o | output | 1 | One-cycle call request to the core |
| call_vec_o | output | 8 | Vector address that goes with the call request |
| wake_o | output | 1 | Wake-up request from power-down |

## Verification
The bench goes after collisions. It drives an event strobe in the same cycle as a software clear: a design that lets the write win would lose a request. It raises all four events together: a wrong priority chain would send the core to the SPI B vector first. It acknowledges during CALL: a design that accepts this would clear the flag before the core has left. It also masks requests through the serial-bus enable and through a full stack. A design that forgets either condition would call with no room to push the return address. Finally it checks that a masked flag survives until the global enable is written again. A design that dropped masked flags would never serve the A/D request that came in during service.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned IRQ_SRC_N  = 4;
    localparam int unsigned IRQ_IDX_W  = $clog2(IRQ_SRC_N);
    localparam int unsigned IRQ_DATA_W = 8;
    localparam int unsigned IRQ_VEC_W  = 8;

    localparam logic [IRQ_VEC_W-1:0] IRQ_VEC_BASE = 8'h08;
    localparam logic [IRQ_VEC_W-1:0] IRQ_VEC_STEP = 8'h04;

    // bit i set: source i also needs the serial-bus enable
    localparam logic [IRQ_SRC_N-1:0] IRQ_BUS_GATED = 4'b1100;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_CALL = 2'd1,
        SEQ_WAIT = 2'd2
    } seq_state_t;

    function automatic logic [IRQ_VEC_W-1:0] vec_of(input logic [IRQ_IDX_W-1:0] idx);
        return IRQ_VEC_BASE + IRQ_VEC_STEP * IRQ_VEC_W'(idx);
    endfunction

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = IRQ_SRC_N,
    parameter int unsigned DW   = IRQ_DATA_W,
    parameter int unsigned IW   = IRQ_IDX_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic            addr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic            svc_i,
    input  logic [IW-1:0]   svc_idx_i,
    output logic [NSRC-1:0] flag_o,
    output logic [NSRC-1:0] en_o,
    output logic            gie_o,
    output logic            bus_o,
    output logic [DW-1:0]   rdata_o
);

    localparam int unsigned GIE_BIT = 0;
    localparam int unsigned BUS_BIT = 1;
    localparam int unsigned EN_LSB  = 2;
    localparam int unsigned EN_MSB  = EN_LSB + NSRC - 1;

    logic          wr_en_reg;
    logic          wr_flag_reg;
    logic [DW-1:0] img_en;
    logic [DW-1:0] img_flag;
    logic          unused_wbits;

    assign wr_en_reg    = wr_i && (addr_i == 1'b0);
    assign wr_flag_reg  = wr_i && (addr_i == 1'b1);
    assign unused_wbits = ^wdata_i[DW-1:EN_MSB+1];

    // per-source pending flag and enable
    // priority on a flag: event set > acknowledge clear > software write
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_o[s] <= 1'b0;
            end else if (evt_i[s]) begin
                flag_o[s] <= 1'b1;
            end else if (svc_i && (svc_idx_i == IW'(s))) begin
                flag_o[s] <= 1'b0;
            end else if (wr_flag_reg) begin
                flag_o[s] <= wdata_i[s];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_o[s] <= 1'b0;
            end else if (wr_en_reg) begin
                en_o[s] <= wdata_i[EN_LSB+s];
            end
        end
    end

    // global enable: the acknowledge clear wins over a software write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gie_o <= 1'b0;
        end else if (svc_i) begin
            gie_o <= 1'b0;
        end else if (wr_en_reg) begin
            gie_o <= wdata_i[GIE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_o <= 1'b0;
        end else if (wr_en_reg) begin
            bus_o <= wdata_i[BUS_BIT];
        end
    end

    // read images
    always_comb begin
        img_en          = '0;
        img_en[GIE_BIT] = gie_o;
        img_en[BUS_BIT] = bus_o;
        img_en[EN_MSB:EN_LSB] = en_o;
        img_flag             = '0;
        img_flag[NSRC-1:0]   = flag_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            rdata_o <= addr_i ? img_flag : img_en;
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio
    import irqc_pkg::*;
#(
    parameter int unsigned     NSRC      = IRQ_SRC_N,
    parameter int unsigned     IW        = IRQ_IDX_W,
    parameter logic [NSRC-1:0] BUS_GATED = IRQ_BUS_GATED
) (
    input  logic [NSRC-1:0] flag_i,
    input  logic [NSRC-1:0] en_i,
    input  logic            gie_i,
    input  logic            bus_i,
    input  logic            stack_full_i,
    output logic            any_o,
    output logic [IW-1:0]   idx_o
);

    logic [NSRC-1:0] elig;

    for (genvar s = 0; s < NSRC; s++) begin : g_elig
        if (BUS_GATED[s]) begin : g_bus
            assign elig[s] = gie_i && en_i[s] && flag_i[s] && bus_i && !stack_full_i;
        end else begin : g_plain
            assign elig[s] = gie_i && en_i[s] && flag_i[s] && !stack_full_i;
        end
    end

    // lowest index (lowest vector) wins: scan downward so the last hit stays
    always_comb begin
        idx_o = '0;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (elig[s]) begin
                idx_o = IW'(s);
            end
        end
    end

    assign any_o = |elig;

endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int unsigned IW = IRQ_IDX_W,
    parameter int unsigned VW = IRQ_VEC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_i,
    input  logic [IW-1:0] idx_i,
    input  logic          ack_i,
    output seq_state_t    state_o,
    output logic          req_o,
    output logic [VW-1:0] vec_o,
    output logic          svc_o,
    output logic [IW-1:0] svc_idx_o
);

    seq_state_t    state_q;
    seq_state_t    state_d;
    logic [IW-1:0] src_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // source latched on the take transition
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
        end else if ((state_q == SEQ_IDLE) && any_i) begin
            src_q <= idx_i;
        end
    end

    // transitions: take, issue, ack
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (any_i) state_d = SEQ_CALL;
            SEQ_CALL: state_d = SEQ_WAIT;
            SEQ_WAIT: if (ack_i) state_d = SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_o     = 1'b0;
        vec_o     = '0;
        svc_o     = 1'b0;
        svc_idx_o = src_q;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_CALL: begin
                req_o = 1'b1;
                vec_o = vec_of(src_q);
            end
            SEQ_WAIT: svc_o = ack_i;
            default:  ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irqc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tmr_ovf_i,
    input  logic                  adc_done_i,
    input  logic                  spi_a_done_i,
    input  logic                  spi_b_done_i,
    input  logic                  stack_full_i,
    input  logic                  call_ack_i,
    input  logic                  reg_wr_i,
    input  logic                  reg_rd_i,
    input  logic                  reg_addr_i,
    input  logic [IRQ_DATA_W-1:0] reg_wdata_i,
    output logic [IRQ_DATA_W-1:0] reg_rdata_o,
    output logic                  call_req_o,
    output logic [IRQ_VEC_W-1:0]  call_vec_o,
    output logic                  wake_o
);

    logic [IRQ_SRC_N-1:0] evt;
    logic [IRQ_SRC_N-1:0] flag_q;
    logic [IRQ_SRC_N-1:0] en_q;
    logic                 gie_q;
    logic                 bus_q;
    logic                 take_any;
    logic [IRQ_IDX_W-1:0] take_idx;
    logic                 svc;
    logic [IRQ_IDX_W-1:0] svc_idx;
    seq_state_t           seq_state;

    // source order fixes both priority and vector
    assign evt = {spi_b_done_i, spi_a_done_i, adc_done_i, tmr_ovf_i};

    irqc_regs #(
        .NSRC (IRQ_SRC_N),
        .DW   (IRQ_DATA_W),
        .IW   (IRQ_IDX_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (evt),
        .wr_i      (reg_wr_i),
        .rd_i      (reg_rd_i),
        .addr_i    (reg_addr_i),
        .wdata_i   (reg_wdata_i),
        .svc_i     (svc),
        .svc_idx_i (svc_idx),
        .flag_o    (flag_q),
        .en_o      (en_q),
        .gie_o     (gie_q),
        .bus_o     (bus_q),
        .rdata_o   (reg_rdata_o)
    );

    irqc_prio #(
        .NSRC      (IRQ_SRC_N),
        .IW        (IRQ_IDX_W),
        .BUS_GATED (IRQ_BUS_GATED)
    ) u_prio (
        .flag_i       (flag_q),
        .en_i         (en_q),
        .gie_i        (gie_q),
        .bus_i        (bus_q),
        .stack_full_i (stack_full_i),
        .any_o        (take_any),
        .idx_o        (take_idx)
    );

    irqc_seq #(
        .IW (IRQ_IDX_W),
        .VW (IRQ_VEC_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_i     (take_any),
        .idx_i     (take_idx),
        .ack_i     (call_ack_i),
        .state_o   (seq_state),
        .req_o     (call_req_o),
        .vec_o     (call_vec_o),
        .svc_o     (svc),
        .svc_idx_o (svc_idx)
    );

    assign wake_o = |(flag_q & en_q);

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [IRQ_SRC_N-1:0] evt,
    input logic [IRQ_SRC_N-1:0] flag_q,
    input logic                 gie_q,
    input logic                 bus_q,
    input logic                 stack_full_i,
    input logic                 call_ack_i,
    input logic                 reg_wr_i,
    input logic                 call_req_o,
    input logic [IRQ_VEC_W-1:0] call_vec_o,
    input seq_state_t           seq_state
);

    // R3: call request lasts a single cycle
    assert_req_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |=> !call_req_o);

    // R3: a call needs the global enable in the take cycle
    assert_req_needs_gie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> $past(gie_q));

    // R3: full stack in IDLE blocks the next call
    assert_stack_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_IDLE && stack_full_i) |=> !call_req_o);

    // R3: SPI vectors need the serial-bus enable
    assert_spi_needs_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req_o && call_vec_o >= 8'h10) |-> $past(bus_q));

    // R4: only the four defined vectors appear
    assert_vec_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        call_req_o |-> (call_vec_o == 8'h08 || call_vec_o == 8'h0C ||
                        call_vec_o == 8'h10 || call_vec_o == 8'h14));

    // R2: each event strobe leaves its flag set
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flag_q & $past(evt)) == $past(evt)));

    // R6: acknowledge in WAIT drops the global enable
    assert_ack_clears_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_WAIT && call_ack_i) |=> !gie_q);

    // R7: with no event, write or acknowledge, flags hold
    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt == '0 && !reg_wr_i && !(seq_state == SEQ_WAIT && call_ack_i))
        |=> $stable(flag_q));

    // R7: no call while an acknowledge is outstanding
    assert_no_call_in_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == SEQ_WAIT) |-> !call_req_o);

endmodule

bind irq_vector_ctrl irqc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt          (evt),
    .flag_q       (flag_q),
    .gie_q        (gie_q),
    .bus_q        (bus_q),
    .stack_full_i (stack_full_i),
    .call_ack_i   (call_ack_i),
    .reg_wr_i     (reg_wr_i),
    .call_req_o   (call_req_o),
    .call_vec_o   (call_vec_o),
    .seq_state    (seq_state)
);

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] evt = 4'h0;
    logic       stack_full = 1'b0;
    logic       ack = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       call_req;
    logic [7:0] call_vec;
    logic       wake;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_vector_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .tmr_ovf_i    (evt[0]),
        .adc_done_i   (evt[1]),
        .spi_a_done_i (evt[2]),
        .spi_b_done_i (evt[3]),
        .stack_full_i (stack_full),
        .call_ack_i   (ack),
        .reg_wr_i     (wr),
        .reg_rd_i     (rd),
        .reg_addr_i   (addr),
        .reg_wdata_i  (wdata),
        .reg_rdata_o  (rdata),
        .call_req_o   (call_req),
        .call_vec_o   (call_vec),
        .wake_o       (wake)
    );

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int       m_state;   // 0 idle, 1 calling, 2 waiting
    int       m_src;
    bit [3:0] m_flag;
    bit [3:0] m_en;
    bit       m_gie;
    bit       m_bus;
    bit [7:0] m_rd;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_src = 0; m_flag = 0; m_en = 0;
            m_gie = 0; m_bus = 0; m_rd = 0;
        end else begin
            int pick;
            bit svc;
            bit [3:0] nf;
            pick = -1;
            for (int i = 0; i < 4; i++) begin
                if (pick < 0 && m_gie && m_en[i] && m_flag[i] && !stack_full &&
                    (i < 2 || m_bus))
                    pick = i;
            end
            svc = (m_state == 2) && ack;
            if (rd) m_rd = addr ? {4'h0, m_flag} : {2'b00, m_en, m_bus, m_gie};
            nf = m_flag;
            if (wr && addr) nf = wdata[3:0];
            if (svc) nf[m_src] = 1'b0;
            nf = nf | evt;
            if (wr && !addr) begin
                m_gie = wdata[0]; m_bus = wdata[1]; m_en = wdata[5:2];
            end
            if (svc) m_gie = 1'b0;
            m_flag = nf;
            case (m_state)
                0: if (pick >= 0) begin m_state = 1; m_src = pick; end
                1: m_state = 2;
                default: if (ack) m_state = 0;
            endcase
        end
    end

    // compare against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 call_req", call_req, (m_state == 1) ? 1 : 0);
            check("R4 call_vec", call_vec, (m_state == 1) ? 8 + 4 * m_src : 0);
            check("R10 wake", wake, |(m_flag & m_en));
            check("R8 rdata", rdata, m_rd);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input bit a, input bit [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_read(input bit a, output bit [7:0] v);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic pulse(input bit [3:0] e);
        evt = e;
        @(negedge clk);
        evt = 4'h0;
    endtask

    task automatic serve(input string tag, input int exp_vec);
        int n = 0;
        while (!call_req && n < 20) begin
            @(negedge clk);
            n++;
        end
        check(tag, call_req, 1);
        check(tag, call_vec, exp_vec);
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic quiet(input string tag, input int n);
        int seen = 0;
        repeat (n) begin
            @(negedge clk);
            if (call_req) seen++;
        end
        check(tag, seen, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- scenario ----------------
    initial begin
        bit [7:0] v;
        tick(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 req", call_req, 0);
        check("R1 wake", wake, 0);
        check("R1 rdata", rdata, 0);
        reg_read(1'b0, v); check("R1 enables", v, 8'h00);
        reg_read(1'b1, v); check("R1 flags", v, 8'h00);

        // R8 write/read back of the enable register
        reg_write(1'b0, 8'h3F);
        reg_read(1'b0, v); check("R8 enables readback", v, 8'h3F);

        // R4 timer vector, R6 flag and global enable cleared on ack
        pulse(4'b0001);
        serve("R4 timer vector", 8'h08);
        tick(1);
        reg_read(1'b1, v); check("R6 flag cleared", v, 8'h00);
        reg_read(1'b0, v); check("R6 gie cleared", v, 8'h3E);

        // R7 masked flag stays, R9 re-arm
        pulse(4'b0010);
        quiet("R7 masked no call", 6);
        reg_read(1'b1, v); check("R7 flag pending", v, 8'h02);
        reg_write(1'b0, 8'h3F);
        serve("R9 re-arm takes A/D", 8'h0C);
        tick(1);

        // R5 simultaneous requests, lowest vector first
        pulse(4'b1111);
        reg_write(1'b0, 8'h3F); serve("R5 first timer", 8'h08);  tick(1);
        reg_write(1'b0, 8'h3F); serve("R5 second A/D", 8'h0C);   tick(1);
        reg_write(1'b0, 8'h3F); serve("R5 third SPI A", 8'h10);  tick(1);
        reg_write(1'b0, 8'h3F); serve("R5 fourth SPI B", 8'h14); tick(1);
        reg_read(1'b1, v); check("R5 all served", v, 8'h00);

        // R3 serial-bus enable gates SPI
        reg_write(1'b0, 8'h3D);
        pulse(4'b0100);
        quiet("R3 no SPI without bus enable", 6);
        reg_write(1'b0, 8'h3F);
        serve("R3 SPI A after bus enable", 8'h10);
        tick(1);

        // R3 full stack blocks
        stack_full = 1'b1;
        reg_write(1'b0, 8'h3F);
        pulse(4'b0001);
        quiet("R3 stack full blocks", 6);
        stack_full = 1'b0;
        serve("R3 taken after stack frees", 8'h08);
        tick(1);

        // R2 event beats a software clear in the same cycle
        wr = 1'b1; addr = 1'b1; wdata = 8'h00; evt = 4'b0010;
        @(negedge clk);
        wr = 1'b0; evt = 4'h0;
        reg_read(1'b1, v); check("R2 event wins over clear", v, 8'h02);
        reg_write(1'b1, 8'h00);
        reg_read(1'b1, v); check("R8 software clear", v, 8'h00);

        // R6 acknowledge during CALL is ignored
        reg_write(1'b0, 8'h3F);
        pulse(4'b0001);
        while (!call_req) @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        tick(2);
        reg_read(1'b1, v); check("R6 early ack ignored", v, 8'h01);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        tick(1);
        reg_read(1'b1, v); check("R6 ack in wait clears", v, 8'h00);

        // R10 wake follows flag and source enable only
        reg_write(1'b0, 8'h00);
        pulse(4'b0001);
        check("R10 wake off without enable", wake, 0);
        reg_write(1'b0, 8'h04);
        check("R10 wake with enable, no gie", wake, 1);
        quiet("R10 no call without gie", 3);
        reg_write(1'b1, 8'h00);
        check("R10 wake drops after clear", wake, 0);

        tick(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule